// File: doc/BRIEF.md
# Column-Addressed Line Buffer

This block keeps a small two-dimensional store of recent image samples, organised as a grid of rows and columns (three rows by five columns by default). A window or filter stage that walks across an image keeps the last few lines of pixels here. Each arriving pixel updates only the column it belongs to. That column can be shifted down or up by one row, or given a new value in its top or bottom cell. The rest of the grid is left alone.

Commands arrive as an opcode, a column index, a data value and a valid strobe, and each one is applied on the rising clock edge where the strobe is high. A separate read port, with no register in its path, returns the cell at any row and column from the current contents. A filter stage can therefore sample the grid in the same cycle as it issues the next command.

Top module: `col_line_store`

## Requirements
- R1: An active-low reset clears every cell of the grid to zero.
- R2: The read port returns the cell at (`rd_row`, `rd_col`) from the current contents, with no clock delay. A row index of `ROWS` or more, or a column index of `COLS` or more, reads as zero.
- R3: Shift-down (`cmd_op` = 2'b00) on column c moves the cell in row r to row r+1 for every r below `ROWS`-1, and the old bottom value is lost. Row 0 keeps its previous value.
- R4: Shift-up (`cmd_op` = 2'b01) on column c moves the cell in row r to row r-1 for every r above 0, and the old top value is lost. Row `ROWS`-1 keeps its previous value.
- R5: Insert-top (`cmd_op` = 2'b10) writes `cmd_data` into row 0 of column c, and all other cells are unchanged.
- R6: Insert-bottom (`cmd_op` = 2'b11) writes `cmd_data` into row `ROWS`-1 of column c, and all other cells are unchanged.
- R7: A command changes only the selected column. No cell changes in a cycle where `cmd_valid` is low.
- R8: A command with `cmd_col` of `COLS` or more is ignored, and the whole grid keeps its contents.
- R9: Starting from rows {1..5}, {6..10}, {11..15}, a shift-down of column 2 followed by an insert-top of 100 into column 2 leaves column 2 as {100, 3, 8} from top to bottom. The other columns stay as they were.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Apply the command on this edge |
| cmd_op | input | 2 | 00 shift down, 01 shift up, 10 insert top, 11 insert bottom |
| cmd_col | input | CW | Column the command acts on |
| cmd_data | input | DW | Value written by the insert commands |
| rd_row | input | RW | Row to read |
| rd_col | input | CW | Column to read |
| rd_data | output | DW | Cell at the addressed row and column |

## Verification
The grid is first filled through insert and shift commands with a known ascending pattern. The worked example is then replayed on column 2, which shows whether each shift moves data in the right direction and leaves the vacated cell holding its old value. Each opcode is then aimed at column indices past the last column, and also issued with the strobe low, to tell an ignored command apart from one that reaches a neighbouring column. A long pseudo-random command stream then mixes all four opcodes over in-range and out-of-range columns, and the whole grid is compared after every step, including reads addressed outside the grid.

// File: rtl/col_line_store_pkg.sv
package col_line_store_pkg;

    typedef enum logic [1:0] {
        CLS_SHIFT_DOWN = 2'b00,
        CLS_SHIFT_UP   = 2'b01,
        CLS_INS_TOP    = 2'b10,
        CLS_INS_BOTTOM = 2'b11
    } cls_op_e;

endpackage

// File: rtl/cls_col_decode.sv
module cls_col_decode #(
    parameter int COLS = 5,
    parameter int CW   = 3
) (
    input  logic            valid,
    input  logic [CW-1:0]   col,
    output logic [COLS-1:0] sel
);
    for (genvar c = 0; c < COLS; c++) begin : g_sel
        assign sel[c] = valid && (col == CW'(c));
    end
endmodule

// File: rtl/cls_col_next.sv
module cls_col_next
    import col_line_store_pkg::*;
#(
    parameter int ROWS = 3,
    parameter int DW   = 8
) (
    input  logic                      sel,
    input  cls_op_e                   op,
    input  logic [DW-1:0]             data,
    input  logic [ROWS-1:0][DW-1:0]   col_q,
    output logic [ROWS-1:0][DW-1:0]   col_d
);
    always_comb begin
        col_d = col_q;
        if (sel) begin
            unique case (op)
                CLS_SHIFT_DOWN: begin
                    for (int r = 1; r < ROWS; r++) col_d[r] = col_q[r-1];
                end
                CLS_SHIFT_UP: begin
                    for (int r = 0; r < ROWS - 1; r++) col_d[r] = col_q[r+1];
                end
                CLS_INS_TOP:    col_d[0]      = data;
                CLS_INS_BOTTOM: col_d[ROWS-1] = data;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/cls_read_mux.sv
module cls_read_mux #(
    parameter int ROWS = 3,
    parameter int COLS = 5,
    parameter int DW   = 8,
    parameter int RW   = 2,
    parameter int CW   = 3
) (
    input  logic [COLS-1:0][ROWS-1:0][DW-1:0] cells,
    input  logic [RW-1:0]                     row,
    input  logic [CW-1:0]                     col,
    output logic [DW-1:0]                     data
);
    always_comb begin
        data = '0;
        for (int c = 0; c < COLS; c++) begin
            for (int r = 0; r < ROWS; r++) begin
                if (col == CW'(c) && row == RW'(r)) data = cells[c][r];
            end
        end
    end
endmodule

// File: rtl/col_line_store.sv
module col_line_store
    import col_line_store_pkg::*;
#(
    parameter int ROWS = 3,
    parameter int COLS = 5,
    parameter int DW   = 8,
    localparam int RW  = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int CW  = (COLS > 1) ? $clog2(COLS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [1:0]    cmd_op,
    input  logic [CW-1:0] cmd_col,
    input  logic [DW-1:0] cmd_data,
    input  logic [RW-1:0] rd_row,
    input  logic [CW-1:0] rd_col,
    output logic [DW-1:0] rd_data
);
    typedef struct packed {
        logic [COLS-1:0][ROWS-1:0][DW-1:0] cells;
    } state_t;

    state_t state_d, state_q;

    logic [COLS-1:0]                   col_sel;
    logic [COLS-1:0][ROWS-1:0][DW-1:0] col_nxt;

    cls_col_decode #(.COLS(COLS), .CW(CW)) u_dec (
        .valid (cmd_valid),
        .col   (cmd_col),
        .sel   (col_sel)
    );

    for (genvar c = 0; c < COLS; c++) begin : g_col
        cls_col_next #(.ROWS(ROWS), .DW(DW)) u_next (
            .sel   (col_sel[c]),
            .op    (cls_op_e'(cmd_op)),
            .data  (cmd_data),
            .col_q (state_q.cells[c]),
            .col_d (col_nxt[c])
        );
    end

    always_comb begin
        state_d = state_q;
        for (int c = 0; c < COLS; c++) state_d.cells[c] = col_nxt[c];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    cls_read_mux #(.ROWS(ROWS), .COLS(COLS), .DW(DW), .RW(RW), .CW(CW)) u_rd (
        .cells (state_q.cells),
        .row   (rd_row),
        .col   (rd_col),
        .data  (rd_data)
    );
endmodule

// File: rtl/cls_checker.sv
module cls_checker
    import col_line_store_pkg::*;
#(
    parameter int ROWS = 3,
    parameter int COLS = 5,
    parameter int DW   = 8,
    parameter int RW   = 2,
    parameter int CW   = 3
) (
    input logic                              clk,
    input logic                              rst_n,
    input logic                              cmd_valid,
    input logic [1:0]                        cmd_op,
    input logic [CW-1:0]                     cmd_col,
    input logic [DW-1:0]                     cmd_data,
    input logic [RW-1:0]                     rd_row,
    input logic [CW-1:0]                     rd_col,
    input logic [DW-1:0]                     rd_data,
    input logic [COLS-1:0][ROWS-1:0][DW-1:0] cells
);
    for (genvar c = 0; c < COLS; c++) begin : g_c
        // R7 and R8: a column not addressed by a valid command holds
        a_r7_untouched_col: assert property (@(posedge clk) disable iff (!rst_n)
            (!cmd_valid || cmd_col != CW'(c)) |=> cells[c] == $past(cells[c]));

        // R5
        a_r5_insert_top: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd_valid && cmd_col == CW'(c) && cmd_op == CLS_INS_TOP)
            |=> cells[c][0] == $past(cmd_data));

        // R6
        a_r6_insert_bottom: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd_valid && cmd_col == CW'(c) && cmd_op == CLS_INS_BOTTOM)
            |=> cells[c][ROWS-1] == $past(cmd_data));

        // R3: vacated top cell keeps its value
        a_r3_top_kept: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd_valid && cmd_col == CW'(c) && cmd_op == CLS_SHIFT_DOWN)
            |=> cells[c][0] == $past(cells[c][0]));

        // R4: vacated bottom cell keeps its value
        a_r4_bottom_kept: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd_valid && cmd_col == CW'(c) && cmd_op == CLS_SHIFT_UP)
            |=> cells[c][ROWS-1] == $past(cells[c][ROWS-1]));

        for (genvar r = 1; r < ROWS; r++) begin : g_r
            // R3
            a_r3_shift_down: assert property (@(posedge clk) disable iff (!rst_n)
                (cmd_valid && cmd_col == CW'(c) && cmd_op == CLS_SHIFT_DOWN)
                |=> cells[c][r] == $past(cells[c][r-1]));
            // R4
            a_r4_shift_up: assert property (@(posedge clk) disable iff (!rst_n)
                (cmd_valid && cmd_col == CW'(c) && cmd_op == CLS_SHIFT_UP)
                |=> cells[c][r-1] == $past(cells[c][r]));
        end
    end

    // R2: reads outside the grid return zero
    always @(negedge clk) begin
        if (rst_n && (int'(rd_row) >= ROWS || int'(rd_col) >= COLS)) begin
            a_r2_oob_zero: assert (rd_data == '0);
        end
    end
endmodule

bind col_line_store cls_checker #(
    .ROWS(ROWS), .COLS(COLS), .DW(DW), .RW(RW), .CW(CW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_col   (cmd_col),
    .cmd_data  (cmd_data),
    .rd_row    (rd_row),
    .rd_col    (rd_col),
    .rd_data   (rd_data),
    .cells     (state_q.cells)
);

// File: tb/tb_col_line_store.sv
`timescale 1ns/1ps
module tb_col_line_store;
    localparam int ROWS = 3;
    localparam int COLS = 5;
    localparam int DW   = 8;
    localparam int RW   = 2;
    localparam int CW   = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [1:0]    cmd_op = 2'b00;
    logic [CW-1:0] cmd_col = '0;
    logic [DW-1:0] cmd_data = '0;
    logic [RW-1:0] rd_row = '0;
    logic [CW-1:0] rd_col = '0;
    logic [DW-1:0] rd_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    int exp_q [COLS][ROWS];

    always #2 clk = ~clk;

    col_line_store #(.ROWS(ROWS), .COLS(COLS), .DW(DW)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_col(cmd_col), .cmd_data(cmd_data), .rd_row(rd_row),
        .rd_col(rd_col), .rd_data(rd_data)
    );

    task automatic model(input int op, input int col, input int data);
        if (col >= COLS) return;
        case (op)
            0: for (int r = ROWS - 1; r > 0; r--) exp_q[col][r] = exp_q[col][r-1];
            1: for (int r = 0; r < ROWS - 1; r++) exp_q[col][r] = exp_q[col][r+1];
            2: exp_q[col][0] = data;
            default: exp_q[col][ROWS-1] = data;
        endcase
    endtask

    task automatic issue(input bit v, input int op, input int col, input int data);
        @(negedge clk);
        cmd_valid = v;
        cmd_op    = 2'(op);
        cmd_col   = CW'(col);
        cmd_data  = DW'(data);
        @(posedge clk);
        #1;
        cmd_valid = 1'b0;
        if (v) model(op, col, data % 256);
    endtask

    task automatic check_cell(input int r, input int c, input int expv, input string tag);
        rd_row = RW'(r);
        rd_col = CW'(c);
        #1;
        checks++;
        if (int'(rd_data) != expv) begin
            errors++;
            $display("FAIL %s row %0d col %0d: got %0d expected %0d",
                     tag, r, c, rd_data, expv);
        end
    endtask

    task automatic check_all(input string tag);
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++)
                check_cell(r, c, exp_q[c][r], tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, got hung expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < COLS; c++)
            for (int r = 0; r < ROWS; r++) exp_q[c][r] = 0;
        cmd_op = 2'b10; cmd_data = 8'hff; cmd_col = 3'd1;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset contents
        check_all("R1 reset");

        // Fill rows with 1..5, 6..10, 11..15 via insert-top and shift-down
        for (int c = 0; c < COLS; c++) begin
            for (int r = ROWS - 1; r >= 0; r--) begin
                issue(1, 2, c, r * COLS + c + 1);
                if (r > 0) issue(1, 0, c, 0);
            end
        end
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++)
                check_cell(r, c, r * COLS + c + 1, "R3 R5 fill pattern");

        // R9: worked example on column 2
        issue(1, 0, 2, 0);
        check_cell(0, 2, 3, "R3 top kept after shift-down");
        check_cell(1, 2, 3, "R3 shifted row1");
        check_cell(2, 2, 8, "R3 shifted row2");
        issue(1, 2, 2, 100);
        check_cell(0, 2, 100, "R9 row0");
        check_cell(1, 2, 3, "R9 row1");
        check_cell(2, 2, 8, "R9 row2");
        check_cell(1, 3, 9, "R9 neighbour col3");
        check_all("R7 after example");

        // R4: shift-up on column 0 -> {6, 11, 11}
        issue(1, 1, 0, 0);
        check_cell(0, 0, 6, "R4 row0");
        check_cell(1, 0, 11, "R4 row1");
        check_cell(2, 0, 11, "R4 bottom kept");

        // R6: insert-bottom on column 4
        issue(1, 3, 4, 77);
        check_cell(2, 4, 77, "R6 bottom written");
        check_cell(1, 4, 10, "R6 row1 unchanged");
        check_all("R6 grid");

        // R8: out-of-range columns ignored for every opcode
        for (int col = COLS; col < 8; col++)
            for (int op = 0; op < 4; op++) begin
                issue(1, op, col, 200 + op);
                check_all("R8 oob column");
            end

        // R7: strobe low has no effect
        for (int op = 0; op < 4; op++) begin
            issue(0, op, 1, 55);
            check_all("R7 valid low");
        end

        // R2: reads outside the grid return zero
        for (int c = 0; c < 8; c++) check_cell(ROWS, c, 0, "R2 oob row");
        for (int r = 0; r < 4; r++)
            for (int c = COLS; c < 8; c++) check_cell(r, c, 0, "R2 oob col");

        // Pseudo-random command stream
        begin
            logic [15:0] lfsr = 16'hace1;
            for (int i = 0; i < 300; i++) begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                issue(lfsr[5] | lfsr[6], int'(lfsr[1:0]), int'(lfsr[4:2]),
                      int'(lfsr[15:8]));
                check_all("R7 random stream");
            end
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule